// File: doc/BRIEF.md
# Credit-Gated Router Port Adapter

This block sits between a flit serializer/deserializer and a single port of an on-chip network router, all in one clock domain. On the outbound path, flits from the user side are queued in a small synchronous FIFO and released to the router one per cycle. A release happens only while the sender holds at least one credit. Credits start at the far buffer's capacity. Each release spends one credit, and each credit strobe from the router refunds one.

On the inbound path, flits delivered by the router are queued in a second FIFO and presented to the user with valid/ready. A credit goes back to the router in the same cycle that the user takes a flit, so the credits the router sees track real free space in this buffer rather than arrivals. The returned credit carries the virtual-channel number held in the dequeued flit. If a flit arrives while the inbound FIFO is full, it is dropped and a sticky error flag is raised.

Top module: `credit_port_link`

## Requirements
- R1: After reset (rst_n low), tx_credits equals CREDITS, both FIFOs are empty, tx_ready is 1, rx_valid, net_put_en, net_credit_out_en and rx_overflow are 0, and both almost-empty flags are 1.
- R2: net_put_en is high in a cycle exactly when the outbound FIFO holds a flit and tx_credits is nonzero. net_put_flit then carries the oldest queued flit, and flits leave in the order they were accepted.
- R3: tx_credits drops by one on a cycle with a send and no incoming credit, and rises by one on a cycle with an incoming credit (net_credit_in) and no send. It stays unchanged when both happen together. It never exceeds CREDITS, and a credit that arrives at the maximum is discarded.
- R4: tx_ready is 0 while the outbound FIFO holds DEPTH flits. A tx_valid offered while tx_ready is 0 is not stored.
- R5: Each FIFO's almost-full flag is 1 when it holds DEPTH-1 or more flits. Each FIFO's almost-empty flag is 1 when it holds at most 1 flit.
- R6: rx_valid is 1 whenever the inbound FIFO is non-empty. rx_flit shows the oldest flit, and flits are delivered in arrival order.
- R7: net_credit_out_en is high in exactly the cycles where rx_valid and rx_ready are both 1. net_credit_out_vc equals the top VC_W bits of the flit being dequeued (bit 15 with the defaults).
- R8: A flit arriving on net_get_en while the inbound FIFO holds DEPTH flits is dropped, and stored flits are unaffected. rx_overflow goes to 1 after that edge and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_flit | input | FLIT_W | Outbound flit from the serializer |
| tx_valid | input | 1 | Outbound flit offered |
| tx_ready | output | 1 | Outbound FIFO can accept |
| tx_almost_full | output | 1 | Outbound FIFO holds at least DEPTH-1 |
| tx_almost_empty | output | 1 | Outbound FIFO holds at most 1 |
| tx_credits | output | $clog2(CREDITS+1) | Current credit count |
| net_put_flit | output | FLIT_W | Flit sent to the router |
| net_put_en | output | 1 | Send strobe to the router |
| net_credit_in | input | 1 | Credit returned by the router |
| net_get_flit | input | FLIT_W | Flit delivered by the router |
| net_get_en | input | 1 | Delivery strobe from the router |
| net_credit_out_en | output | 1 | Credit returned to the router |
| net_credit_out_vc | output | VC_W | Channel of the returned credit |
| rx_flit | output | FLIT_W | Inbound flit to the deserializer |
| rx_valid | output | 1 | Inbound flit available |
| rx_ready | input | 1 | Deserializer takes the flit |
| rx_almost_full | output | 1 | Inbound FIFO holds at least DEPTH-1 |
| rx_almost_empty | output | 1 | Inbound FIFO holds at most 1 |
| rx_overflow | output | 1 | Sticky: an arrival was dropped |

## Verification
A credit count that drifts from the truth shows up at the ports within one cycle of the faulty update, through tx_credits. It then shows up as a send that should not happen, or a send that stalls. The table-driven credit walk covers spend, refund, simultaneous spend and refund, and saturation. A corrupted FIFO pointer or count shows up as an out-of-order or repeated flit, or as a wrong ready or almost flag, on the next dequeue or on the next cycle. The checks therefore fill both FIFOs to their boundaries and drain them while comparing each flit. A mistimed credit return shows up in the same cycle, because it must coincide with the user handshake.

// File: rtl/credit_port_link_pkg.sv
// Shared constants and helpers for the credit-gated router port adapter.
// Assumes the virtual-channel number sits in the top bits of every flit.
package credit_port_link_pkg;

    localparam int unsigned CPL_FLIT_W = 16;
    localparam int unsigned CPL_DEPTH  = 4;
    localparam int unsigned CPL_VC_W   = 1;

    // Number of bits needed to hold values 0..n inclusive.
    function automatic int unsigned cpl_cnt_bits(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cpl_fifo.sv
// Synchronous first-in first-out buffer with occupancy flags.
// A push while full and a pop while empty are ignored internally.
// The head entry is visible on dout without a pop. DEPTH must be 2 or more.
module cpl_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         almost_full,
    output logic         almost_empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    // Occupancy flags derived from the entry count.
    always_comb begin
        empty        = (count == '0);
        full         = (count == CW'(DEPTH));
        almost_full  = (count >= CW'(DEPTH - 1));
        almost_empty = (count <= CW'(1));
        dout         = mem[rd_ptr];
    end

    // Storage write; the contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and count bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/cpl_credit_ctr.sv
// Credit counter for the outbound path. It starts at CREDITS, spends one per send
// and regains one per returned credit, and saturates at CREDITS.
// Assumes the caller raises spend only while avail is high.
module cpl_credit_ctr #(
    parameter int unsigned CREDITS = 4,
    localparam int unsigned CW     = $clog2(CREDITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spend,
    input  logic          refund,
    output logic [CW-1:0] count,
    output logic          avail
);
    assign avail = (count != '0);

    // Count update: spend and refund in the same cycle cancel out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= CW'(CREDITS);
        end else begin
            case ({spend, refund})
                2'b10:   count <= count - 1'b1;
                2'b01:   count <= (count == CW'(CREDITS)) ? count : count + 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/credit_port_link.sv
// Credit-gated adapter between a serializer/deserializer pair and one router port.
// Outbound flits queue and are sent only while credits remain.
// Inbound flits queue, and each user dequeue returns one credit tagged with the flit's channel.
// Single clock; the router honours the credits it is given.
module credit_port_link
    import credit_port_link_pkg::*;
#(
    parameter int unsigned FLIT_W  = CPL_FLIT_W,
    parameter int unsigned DEPTH   = CPL_DEPTH,
    parameter int unsigned CREDITS = DEPTH,
    parameter int unsigned VC_W    = CPL_VC_W,
    localparam int unsigned CRW    = $clog2(CREDITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLIT_W-1:0] tx_flit,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_almost_full,
    output logic              tx_almost_empty,
    output logic [CRW-1:0]    tx_credits,
    output logic [FLIT_W-1:0] net_put_flit,
    output logic              net_put_en,
    input  logic              net_credit_in,
    input  logic [FLIT_W-1:0] net_get_flit,
    input  logic              net_get_en,
    output logic              net_credit_out_en,
    output logic [VC_W-1:0]   net_credit_out_vc,
    output logic [FLIT_W-1:0] rx_flit,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              rx_almost_full,
    output logic              rx_almost_empty,
    output logic              rx_overflow
);
    logic tx_empty, tx_full, credit_avail, send;
    logic rx_empty, rx_full, take;

    // Outbound gating: send whenever a flit waits and a credit is held.
    always_comb begin
        tx_ready   = !tx_full;
        send       = !tx_empty && credit_avail;
        net_put_en = send;
    end

    cpl_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) tx_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(tx_valid), .din(tx_flit), .pop(send), .dout(net_put_flit),
        .empty(tx_empty), .full(tx_full),
        .almost_full(tx_almost_full), .almost_empty(tx_almost_empty)
    );

    cpl_credit_ctr #(.CREDITS(CREDITS)) credit_i (
        .clk(clk), .rst_n(rst_n),
        .spend(send), .refund(net_credit_in),
        .count(tx_credits), .avail(credit_avail)
    );

    // Inbound handshake and credit return tied to the user dequeue.
    always_comb begin
        rx_valid          = !rx_empty;
        take              = rx_valid && rx_ready;
        net_credit_out_en = take;
        net_credit_out_vc = rx_flit[FLIT_W-1 -: VC_W];
    end

    cpl_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) rx_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(net_get_en), .din(net_get_flit), .pop(take), .dout(rx_flit),
        .empty(rx_empty), .full(rx_full),
        .almost_full(rx_almost_full), .almost_empty(rx_almost_empty)
    );

    // Sticky error: an arrival met a full inbound buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rx_overflow <= 1'b0;
        else if (net_get_en && rx_full) rx_overflow <= 1'b1;
    end
endmodule

// File: rtl/credit_port_link_chk.sv
// Port-level property checker for credit_port_link, attached by bind.
// Observes only; drives nothing.
module credit_port_link_chk #(
    parameter int unsigned FLIT_W  = 16,
    parameter int unsigned CREDITS = 4,
    parameter int unsigned VC_W    = 1,
    localparam int unsigned CRW    = $clog2(CREDITS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_ready,
    input logic              tx_almost_full,
    input logic [CRW-1:0]    tx_credits,
    input logic              net_put_en,
    input logic              net_credit_in,
    input logic              net_credit_out_en,
    input logic [VC_W-1:0]   net_credit_out_vc,
    input logic [FLIT_W-1:0] rx_flit,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              rx_overflow
);
    p_put_needs_credit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        net_put_en |-> (tx_credits != '0));

    p_credit_spend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (net_put_en && !net_credit_in) |=> (tx_credits == $past(tx_credits) - 1'b1));

    p_credit_cancel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (net_put_en && net_credit_in) |=> $stable(tx_credits));

    p_credit_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_credits <= CRW'(CREDITS));

    p_ready_when_roomy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_almost_full |-> tx_ready);

    p_credit_on_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        net_credit_out_en |-> (rx_valid && rx_ready));

    p_credit_vc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        net_credit_out_en |-> (net_credit_out_vc == rx_flit[FLIT_W-1 -: VC_W]));

    p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow |=> rx_overflow);
endmodule

bind credit_port_link credit_port_link_chk #(
    .FLIT_W(FLIT_W), .CREDITS(CREDITS), .VC_W(VC_W)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .tx_ready(tx_ready), .tx_almost_full(tx_almost_full), .tx_credits(tx_credits),
    .net_put_en(net_put_en), .net_credit_in(net_credit_in),
    .net_credit_out_en(net_credit_out_en), .net_credit_out_vc(net_credit_out_vc),
    .rx_flit(rx_flit), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_overflow(rx_overflow)
);

// File: tb/credit_port_link_tb_top.sv
// Self-checking bench: a table-driven credit walk, then directed boundary tests.
`timescale 1ns/1ps
module credit_port_link_tb_top;
    localparam real CLK_P = 5.0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] tx_flit, net_get_flit;
    logic        tx_valid, net_credit_in, net_get_en, rx_ready;
    logic        tx_ready, tx_almost_full, tx_almost_empty;
    logic [2:0]  tx_credits;
    logic [15:0] net_put_flit, rx_flit;
    logic        net_put_en, net_credit_out_en;
    logic [0:0]  net_credit_out_vc;
    logic        rx_valid, rx_almost_full, rx_almost_empty, rx_overflow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P / 2) clk = ~clk;

    credit_port_link dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_flit(tx_flit), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_almost_full(tx_almost_full), .tx_almost_empty(tx_almost_empty),
        .tx_credits(tx_credits), .net_put_flit(net_put_flit), .net_put_en(net_put_en),
        .net_credit_in(net_credit_in), .net_get_flit(net_get_flit), .net_get_en(net_get_en),
        .net_credit_out_en(net_credit_out_en), .net_credit_out_vc(net_credit_out_vc),
        .rx_flit(rx_flit), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_almost_full(rx_almost_full), .rx_almost_empty(rx_almost_empty),
        .rx_overflow(rx_overflow)
    );

    // Row: [37] push, [36:21] flit, [20] credit in, [19] expect send,
    //      [18:3] expected sent flit, [2:0] credits after the edge.
    localparam logic [37:0] VEC [0:11] = '{
        {1'b1, 16'hA001, 1'b0, 1'b0, 16'h0000, 3'd4},
        {1'b1, 16'hA002, 1'b0, 1'b1, 16'hA001, 3'd3},
        {1'b1, 16'hA003, 1'b0, 1'b1, 16'hA002, 3'd2},
        {1'b1, 16'hA004, 1'b0, 1'b1, 16'hA003, 3'd1},
        {1'b1, 16'hA005, 1'b0, 1'b1, 16'hA004, 3'd0},
        {1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 3'd0},
        {1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 3'd1},
        {1'b0, 16'h0000, 1'b1, 1'b1, 16'hA005, 3'd1},
        {1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 3'd2},
        {1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 3'd3},
        {1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 3'd4},
        {1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 3'd4}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        tx_valid = 0; tx_flit = '0; net_credit_in = 0;
        net_get_en = 0; net_get_flit = '0; rx_ready = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; idle_inputs();
        do_reset();
        // R1 reset state
        chk("R1", "credits", tx_credits, 4);
        chk("R1", "tx_ready", tx_ready, 1);
        chk("R1", "rx_valid", rx_valid, 0);
        chk("R1", "put_en", net_put_en, 0);
        chk("R1", "credit_out", net_credit_out_en, 0);
        chk("R1", "overflow", rx_overflow, 0);
        chk("R1", "almost_empty", {tx_almost_empty, rx_almost_empty}, 2'b11);

        // R2/R3 table walk: sends, spends, refunds, cancel, saturation
        @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            tx_valid = VEC[i][37]; tx_flit = VEC[i][36:21]; net_credit_in = VEC[i][20];
            #1;
            chk("R2", $sformatf("row %0d put_en", i), net_put_en, VEC[i][19]);
            if (VEC[i][19]) chk("R2", $sformatf("row %0d put_flit", i), net_put_flit, VEC[i][18:3]);
            @(negedge clk);
            chk("R3", $sformatf("row %0d credits", i), tx_credits, VEC[i][2:0]);
        end
        idle_inputs();

        // R4/R5 fill the outbound FIFO once credits run out
        do_reset();
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            tx_valid = 1; tx_flit = 16'hB000 + 16'(k);
            @(negedge clk);
            if (k == 5) chk("R5", "tx almost_full at 2", tx_almost_full, 0);
            if (k == 6) begin
                chk("R5", "tx almost_full at 3", tx_almost_full, 1);
                chk("R4", "ready at 3", tx_ready, 1);
            end
        end
        tx_valid = 0;
        #1;
        chk("R4", "ready when full", tx_ready, 0);
        chk("R2", "no send without credit", net_put_en, 0);
        tx_valid = 1; tx_flit = 16'hDEAD;
        @(negedge clk);
        tx_valid = 0;
        for (int j = 0; j < 4; j++) begin
            net_credit_in = 1;
            @(negedge clk);
            net_credit_in = 0;
            #1;
            chk("R2", "send after credit", net_put_en, 1);
            chk("R4", "order after full", net_put_flit, 16'hB004 + 16'(j));
            @(negedge clk);
        end
        net_credit_in = 1;
        @(negedge clk);
        net_credit_in = 0;
        #1;
        chk("R4", "offer while full not stored", net_put_en, 0);
        chk("R3", "credit held", tx_credits, 1);

        // R5/R6/R7 inbound queue and credit return
        do_reset();
        @(negedge clk);
        net_get_en = 1; net_get_flit = 16'h8011;
        @(negedge clk);
        chk("R5", "rx almost_empty at 1", rx_almost_empty, 1);
        net_get_flit = 16'h0022;
        @(negedge clk);
        net_get_flit = 16'h8033;
        chk("R5", "rx almost_empty at 2", rx_almost_empty, 0);
        @(negedge clk);
        net_get_en = 0;
        #1;
        chk("R5", "rx almost_full at 3", rx_almost_full, 1);
        chk("R6", "rx_valid", rx_valid, 1);
        chk("R7", "no credit without ready", net_credit_out_en, 0);
        rx_ready = 1;
        #1;
        chk("R6", "head 1", rx_flit, 16'h8011);
        chk("R7", "credit on take", net_credit_out_en, 1);
        chk("R7", "vc 1", net_credit_out_vc, 1);
        @(negedge clk); #1;
        chk("R6", "head 2", rx_flit, 16'h0022);
        chk("R7", "vc 0", net_credit_out_vc, 0);
        @(negedge clk); #1;
        chk("R6", "head 3", rx_flit, 16'h8033);
        @(negedge clk);
        rx_ready = 0; #1;
        chk("R6", "drained", rx_valid, 0);
        chk("R7", "no credit when empty", net_credit_out_en, 0);

        // R8 overflow drop and sticky flag
        net_get_en = 1;
        for (int k = 0; k < 5; k++) begin
            net_get_flit = 16'hC000 + 16'(k);
            @(negedge clk);
            if (k == 3) chk("R8", "no flag at full", rx_overflow, 0);
        end
        net_get_en = 0;
        #1;
        chk("R8", "flag set", rx_overflow, 1);
        rx_ready = 1;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk("R8", "kept contents", rx_flit, 16'hC000 + 16'(k));
            @(negedge clk);
        end
        #1;
        chk("R8", "dropped flit absent", rx_valid, 0);
        chk("R8", "flag sticky", rx_overflow, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule